// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Controller

This block moves words between I/O devices and memory without ever holding the data. Each of its four channels is set up by the CPU through a small register port: a start address, a word count and a mode that picks the direction and arms the channel. A device asks for service on its request line. The controller then asks the processor for the system bus and waits for the grant. While it owns the bus it drives the address and raises a memory strobe and the opposite I/O strobe together, so the word passes straight from one side to the other.

Only one channel is active at a time. The lowest-numbered channel that is both requesting and armed wins, and the choice is made only while the controller is idle. A channel keeps the bus word after word for as long as its request and the grant stay high. When a channel's count runs out, the controller hands the bus back, disarms the channel, sets that channel's done flag and raises the interrupt. The flags clear when the CPU reads them.

Top module: `dma4_flyby`

## Requirements
- R1: After reset, hrq, bus_oe, every dack bit, every strobe, addr_out and irq are 0, and every channel register reads back 0.
- R2: The register port is selected by cfg_addr. Bits [3:2] pick the channel and bits [1:0] pick the field: 0 is the current address, 1 is the remaining count, 2 is the mode and 3 is the status. In the mode field, bit 0 is the direction and bit 1 is the enable. Written address, count and mode values read back unchanged.
- R3: An enabled channel's request raises hrq on the next clock edge. bus_oe, dack and all strobes stay low until hlda is high.
- R4: On the first edge that sees hlda high, the controller drives the channel's address with bus_oe high. Its dack bit is one-hot and no strobe is active. dack stays low whenever hrq is low.
- R5: With direction 0 (memory to device), memr and iow are asserted together. With direction 1 (device to memory), ior and memw are asserted together. No other strobe is active at the same time.
- R6: Each word takes exactly four cycles: address setup, strobe assert, strobe hold and release. The strobes are high in the middle two cycles, and the address is stable while they are high. After each word the channel's address rises by 1 and its count falls by 1.
- R7: A count of K moves K+1 words. After the word that is moved with the count at 0, the channel's count reads all ones and its enable bit reads 0. Its status bit is set, irq is high and hrq falls on the same edge.
- R8: Reading the status field returns one bit per channel (bit n is channel n) and clears all of them. irq stays high until that read happens.
- R9: When several armed channels request at once, the lowest-numbered one is served first. A higher-priority request that arrives during a burst does not preempt it. dack never switches directly from one channel to another.
- R10: If hlda falls during a word, that word's strobe sequence still completes. On the next edge, bus_oe, dack, the strobes and addr_out go low.
- R11: A request on a channel whose enable bit is 0 is ignored: hrq stays low and the channel's registers do not change.
- R12: If the serving channel's request is low at the release state, the controller goes idle after that word. A later request resumes from the updated address and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 4 | Register select: channel in [3:2], field in [1:0] |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe; a status read clears the done flags |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| dreq | input | 4 | Per-channel service request |
| dack | output | 4 | Per-channel service acknowledge |
| hrq | output | 1 | Bus hold request to the processor |
| hlda | input | 1 | Bus hold grant from the processor |
| bus_oe | output | 1 | Enable for the address and strobe drivers; when low, the bus is released |
| addr_out | output | 16 | Memory address (0 while released) |
| memr | output | 1 | Memory read strobe |
| memw | output | 1 | Memory write strobe |
| ior | output | 1 | I/O read strobe |
| iow | output | 1 | I/O write strobe |
| irq | output | 1 | Completion interrupt, high while any done flag is set |

## Verification
A bad address or count register shows at the ports within one word: the monitor compares each strobe's address against the programmed start plus the number of words already moved. The final count and address are then read back through the register port. A wrong sequencer state shows within a cycle as a strobe pair of the wrong kind, a strobe high outside the two middle cycles, or a bus driven before the grant. A wrong arbiter or terminal-count decision shows as channels served in the wrong order, a word too many or too few, or irq failing to rise or fall.

// File: rtl/dma_flyby_pkg.sv
package dma_flyby_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_SETUP,
    ST_ASSERT,
    ST_HOLD,
    ST_REL
  } xfer_st_e;

  localparam logic [1:0] FLD_ADDR = 2'd0;
  localparam logic [1:0] FLD_CNT  = 2'd1;
  localparam logic [1:0] FLD_MODE = 2'd2;
  localparam logic [1:0] FLD_STAT = 2'd3;

  localparam int MODE_DIR_BIT = 0;
  localparam int MODE_EN_BIT  = 1;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr,
  input  logic          ld_cnt,
  input  logic          ld_mode,
  input  logic [DW-1:0] wdata,
  input  logic          step,
  input  logic          st_clr,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic          dir,
  output logic          en,
  output logic          tc_flag
);
  import dma_flyby_pkg::*;

  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          dir_q, dir_d;
  logic          en_q, en_d;
  logic          tc_q, tc_d;

  // next-state: CPU loads, then per-word update; terminal count wins over clear
  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    en_d   = en_q;
    tc_d   = tc_q;
    if (ld_addr) addr_d = wdata[AW-1:0];
    if (ld_cnt)  cnt_d  = wdata[CW-1:0];
    if (ld_mode) begin
      dir_d = wdata[MODE_DIR_BIT];
      en_d  = wdata[MODE_EN_BIT];
    end
    if (st_clr) tc_d = 1'b0;
    if (step) begin
      addr_d = addr_q + 1'b1;
      cnt_d  = cnt_q - 1'b1;
      if (cnt_q == '0) begin
        en_d = 1'b0;
        tc_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      en_q   <= 1'b0;
      tc_q   <= 1'b0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      en_q   <= en_d;
      tc_q   <= tc_d;
    end
  end

  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;
  assign dir      = dir_q;
  assign en       = en_q;
  assign tc_flag  = tc_q;

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic [NCH-1:0] req,
  output logic [IW-1:0]  idx,
  output logic           any
);
  // scan from the top so the lowest-numbered requester is left standing
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arb_any,
  input  logic [IW-1:0]  arb_idx,
  input  logic [NCH-1:0] dreq,
  input  logic           hlda,
  input  logic           last_word,
  output logic [IW-1:0]  ch,
  output logic           hrq,
  output logic           bus_oe,
  output logic           strobe_on,
  output logic           step
);
  import dma_flyby_pkg::*;

  xfer_st_e      st_q, st_d;
  logic [IW-1:0] ch_q, ch_d;

  always_comb begin
    st_d = st_q;
    ch_d = ch_q;
    unique case (st_q)
      ST_IDLE: begin
        if (arb_any) begin
          st_d = ST_REQ;
          ch_d = arb_idx;
        end
      end
      ST_REQ: begin
        if (hlda)               st_d = ST_SETUP;
        else if (!dreq[ch_q])   st_d = ST_IDLE;
      end
      ST_SETUP:  st_d = ST_ASSERT;
      ST_ASSERT: st_d = ST_HOLD;
      ST_HOLD:   st_d = ST_REL;
      ST_REL: begin
        if (last_word)                st_d = ST_IDLE;
        else if (hlda && dreq[ch_q])  st_d = ST_SETUP;
        else                          st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ch_q <= '0;
    end else begin
      st_q <= st_d;
      ch_q <= ch_d;
    end
  end

  assign ch        = ch_q;
  assign hrq       = (st_q != ST_IDLE);
  assign bus_oe    = (st_q == ST_SETUP) || (st_q == ST_ASSERT) ||
                     (st_q == ST_HOLD)  || (st_q == ST_REL);
  assign strobe_on = (st_q == ST_ASSERT) || (st_q == ST_HOLD);
  assign step      = (st_q == ST_REL);

endmodule

// File: rtl/dma4_flyby.sv
module dma4_flyby #(
  parameter  int NCH = 4,
  parameter  int AW  = 16,
  parameter  int CW  = 16,
  localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DW  = (AW > CW) ? AW : CW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IW+1:0]  cfg_addr,
  input  logic           cfg_we,
  input  logic           cfg_re,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  cfg_rdata,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  output logic           hrq,
  input  logic           hlda,
  output logic           bus_oe,
  output logic [AW-1:0]  addr_out,
  output logic           memr,
  output logic           memw,
  output logic           ior,
  output logic           iow,
  output logic           irq
);
  import dma_flyby_pkg::*;

  logic [IW-1:0]  cfg_ch;
  logic [1:0]     cfg_fld;
  logic           st_clr;

  logic [AW-1:0]  ch_addr [NCH];
  logic [CW-1:0]  ch_cnt  [NCH];
  logic [NCH-1:0] dir_vec, en_vec, tc_vec;

  logic [IW-1:0]  arb_idx, act_ch;
  logic           arb_any, last_word, strobe_on, step, act_dir;

  assign cfg_ch  = cfg_addr[IW+1:2];
  assign cfg_fld = cfg_addr[1:0];
  assign st_clr  = cfg_re && (cfg_fld == FLD_STAT);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic hit;
    assign hit = (cfg_ch == IW'(g));
    dma_chan_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_addr  (cfg_we && hit && (cfg_fld == FLD_ADDR)),
      .ld_cnt   (cfg_we && hit && (cfg_fld == FLD_CNT)),
      .ld_mode  (cfg_we && hit && (cfg_fld == FLD_MODE)),
      .wdata    (cfg_wdata),
      .step     (step && (act_ch == IW'(g))),
      .st_clr   (st_clr),
      .cur_addr (ch_addr[g]),
      .cur_cnt  (ch_cnt[g]),
      .dir      (dir_vec[g]),
      .en       (en_vec[g]),
      .tc_flag  (tc_vec[g])
    );
  end

  dma_prio_arb #(.NCH(NCH), .IW(IW)) u_arb (
    .req (dreq & en_vec),
    .idx (arb_idx),
    .any (arb_any)
  );

  assign last_word = (ch_cnt[act_ch] == '0);

  dma_xfer_fsm #(.NCH(NCH), .IW(IW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .arb_any   (arb_any),
    .arb_idx   (arb_idx),
    .dreq      (dreq),
    .hlda      (hlda),
    .last_word (last_word),
    .ch        (act_ch),
    .hrq       (hrq),
    .bus_oe    (bus_oe),
    .strobe_on (strobe_on),
    .step      (step)
  );

  assign act_dir  = dir_vec[act_ch];
  assign addr_out = bus_oe ? ch_addr[act_ch] : '0;
  assign dack     = bus_oe ? (NCH'(1) << act_ch) : '0;
  assign memr     = strobe_on && !act_dir;
  assign iow      = strobe_on && !act_dir;
  assign ior      = strobe_on &&  act_dir;
  assign memw     = strobe_on &&  act_dir;
  assign irq      = |tc_vec;

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_fld)
      FLD_ADDR: cfg_rdata = DW'(ch_addr[cfg_ch]);
      FLD_CNT:  cfg_rdata = DW'(ch_cnt[cfg_ch]);
      FLD_MODE: cfg_rdata = DW'({en_vec[cfg_ch], dir_vec[cfg_ch]});
      default:  cfg_rdata = DW'(tc_vec);
    endcase
  end

endmodule

// File: rtl/dma_flyby_chk.sv
module dma_flyby_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hlda,
  input logic           hrq,
  input logic           bus_oe,
  input logic [NCH-1:0] dack,
  input logic [AW-1:0]  addr_out,
  input logic           memr,
  input logic           memw,
  input logic           ior,
  input logic           iow,
  input logic           irq,
  input logic           cfg_re
);
  p_bus_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> hlda);

  p_dack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  p_dack_needs_hrq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> hrq);

  p_mem_rd_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    memr |-> (iow && !ior && !memw));

  p_mem_wr_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    memw |-> (ior && !memr && !iow));

  p_strobe_two_cycles_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memr || memw) |=> (memr || memw));

  p_release_on_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(memr || memw) |-> (bus_oe && (|dack)));

  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (memr || memw) |-> $stable(addr_out));

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cfg_re) |=> irq);

endmodule

bind dma4_flyby dma_flyby_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hlda     (hlda),
  .hrq      (hrq),
  .bus_oe   (bus_oe),
  .dack     (dack),
  .addr_out (addr_out),
  .memr     (memr),
  .memw     (memw),
  .ior      (ior),
  .iow      (iow),
  .irq      (irq),
  .cfg_re   (cfg_re)
);

// File: tb/sim_dma4_flyby.sv
`timescale 1ns/1ps
module sim_dma4_flyby;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack;
  logic        hrq, hlda, bus_oe, memr, memw, ior, iow, irq;
  logic [15:0] addr_out;
  logic        auto_hlda = 1'b0, hlda_man = 1'b0, hlda_auto;

  int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0;
  int wc [4] = '{0, 0, 0, 0};
  int wc_base [4] = '{0, 0, 0, 0};
  logic [15:0] exp_addr [4];
  logic exp_dir [4];
  int ord [64];
  int n_ord = 0, last_ch = -1;
  logic strobe_prev;
  logic [3:0] dack_prev;

  always #2.5 clk = ~clk;
  assign hlda = auto_hlda ? hlda_auto : hlda_man;

  dma4_flyby u0 (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq), .dack(dack), .hrq(hrq),
    .hlda(hlda), .bus_oe(bus_oe), .addr_out(addr_out), .memr(memr), .memw(memw),
    .ior(ior), .iow(iow), .irq(irq)
  );

  // processor model and per-word monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      hlda_auto   <= 1'b0;
      strobe_prev <= 1'b0;
      dack_prev   <= '0;
    end else begin
      hlda_auto <= hrq;
      if (dack_prev != 0 && dack != 0 && dack != dack_prev) begin
        mon_fail++;
        $display("FAIL R9: dack switched %b -> %b without idle", dack_prev, dack);
      end
      if ((memr | memw | ior | iow) && !strobe_prev) begin
        int c;
        logic [15:0] ea;
        c = 0;
        for (int i = 0; i < 4; i++) if (dack[i]) c = i;
        ea = exp_addr[c] + 16'(wc[c] - wc_base[c]);
        mon_chk++;
        if ($countones(dack) != 1 || addr_out != ea) begin
          mon_fail++;
          $display("FAIL R6: ch%0d word addr %0h dack %b expected addr %0h", c, addr_out, dack, ea);
        end
        mon_chk++;
        if (exp_dir[c] ? !(ior && memw && !memr && !iow) : !(memr && iow && !ior && !memw)) begin
          mon_fail++;
          $display("FAIL R5: ch%0d strobes %b%b%b%b expected dir %0d",
                   c, memr, memw, ior, iow, exp_dir[c]);
        end
        wc[c]++;
        if (c != last_ch) begin
          if (n_ord < 64) ord[n_ord] = c;
          n_ord++;
          last_ch = c;
        end
      end
      strobe_prev <= memr | memw | ior | iow;
      dack_prev   <= dack;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [1:0] f, input logic [15:0] d);
    @(negedge clk);
    cfg_addr = {2'(ch), f}; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int ch, input logic [1:0] f, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = {2'(ch), f}; cfg_re = 1'b1;
    #1 d = cfg_rdata;
    @(negedge clk);
    cfg_re = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [15:0] a, input logic [15:0] k,
                      input logic dir, input logic en);
    wr(ch, 2'd0, a);
    wr(ch, 2'd1, k);
    wr(ch, 2'd2, {14'd0, en, dir});
    exp_addr[ch] = a; exp_dir[ch] = dir; wc_base[ch] = wc[ch];
  endtask

  task automatic wait_words(input int ch, input int n);
    for (int i = 0; i < 2000 && (wc[ch] - wc_base[ch]) < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_all();
    logic [15:0] d;
    int b;
    bit seen;
    // ---- R1 reset state
    @(negedge clk);
    chk(!hrq && !bus_oe && dack == 0 && !irq, "R1 outputs", {hrq, bus_oe, irq}, 0);
    chk(!memr && !memw && !ior && !iow && addr_out == 0, "R1 strobes", addr_out, 0);
    for (int c = 0; c < 4; c++) begin
      rd(c, 2'd0, d); chk(d == 0, "R1 addr", d, 0);
      rd(c, 2'd1, d); chk(d == 0, "R1 count", d, 0);
    end
    // ---- R2 register readback
    for (int c = 0; c < 4; c++) begin
      wr(c, 2'd0, 16'hA000 + 16'(c * 17));
      wr(c, 2'd1, 16'h0100 + 16'(c));
      wr(c, 2'd2, 16'(c & 1));
    end
    for (int c = 0; c < 4; c++) begin
      rd(c, 2'd0, d); chk(d == 16'hA000 + 16'(c * 17), "R2 addr", d, 16'hA000 + 16'(c * 17));
      rd(c, 2'd1, d); chk(d == 16'h0100 + 16'(c), "R2 count", d, 16'h0100 + 16'(c));
      rd(c, 2'd2, d); chk(d == 16'(c & 1), "R2 mode", d, c & 1);
    end
    // ---- R3..R7 cycle-exact single word, channel 2, device to memory
    prog(2, 16'h0040, 16'h0000, 1'b1, 1'b1);
    dreq[2] = 1'b1;
    @(negedge clk);
    chk(hrq && !bus_oe && dack == 0, "R3 hrq without bus", {hrq, bus_oe}, 2'b10);
    seen = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (bus_oe || dack != 0 || memr || memw || ior || iow || !hrq) seen = 1'b1;
    end
    chk(!seen, "R3 wait for grant", seen, 0);
    hlda_man = 1'b1;
    @(negedge clk);
    chk(bus_oe && dack == 4'b0100 && addr_out == 16'h0040 && !(memr | memw | ior | iow),
        "R4 setup", {dack, addr_out}, {4'b0100, 16'h0040});
    @(negedge clk);
    chk(ior && memw && !memr && !iow, "R5 dev-to-mem pair", {memr, memw, ior, iow}, 4'b0110);
    @(negedge clk);
    chk(ior && memw && addr_out == 16'h0040, "R6 hold", addr_out, 16'h0040);
    @(negedge clk);
    chk(bus_oe && dack == 4'b0100 && !(memr | memw | ior | iow), "R6 release", bus_oe, 1);
    @(negedge clk);
    chk(!hrq && !bus_oe && dack == 0 && irq, "R7 done edge", {hrq, bus_oe, irq}, 3'b001);
    hlda_man = 1'b0; dreq[2] = 1'b0;
    rd(2, 2'd0, d); chk(d == 16'h0041, "R6 addr step", d, 16'h0041);
    rd(2, 2'd1, d); chk(d == 16'hFFFF, "R7 count wrap", d, 16'hFFFF);
    rd(2, 2'd2, d); chk(d == 16'h0001, "R7 enable cleared", d, 1);
    rd(0, 2'd3, d); chk(d == 16'h0004, "R8 status", d, 4);
    chk(!irq, "R8 irq cleared", irq, 0);
    rd(0, 2'd3, d); chk(d == 0, "R8 status cleared", d, 0);
    // ---- sweep all channels and both directions with the bus granted automatically
    auto_hlda = 1'b1;
    for (int c = 0; c < 4; c++) begin
      for (int dr = 0; dr < 2; dr++) begin
        logic [15:0] a, k;
        a = 16'h1000 * 16'(c + 1) + 16'h0100 * 16'(dr);
        k = 16'(c + dr);
        prog(c, a, k, dr[0], 1'b1);
        dreq[c] = 1'b1;
        for (int i = 0; i < 400 && !irq; i++) @(negedge clk);
        dreq[c] = 1'b0;
        idle(2);
        chk(wc[c] - wc_base[c] == int'(k) + 1, "R7 word count", wc[c] - wc_base[c], int'(k) + 1);
        rd(c, 2'd0, d); chk(d == a + k + 16'd1, "R6 final addr", d, a + k + 16'd1);
        rd(c, 2'd1, d); chk(d == 16'hFFFF, "R7 final count", d, 16'hFFFF);
        rd(c, 2'd2, d); chk(d == 16'(dr), "R7 disarmed", d, dr);
        rd(0, 2'd3, d); chk(d == 16'(1 << c), "R8 status bit", d, 1 << c);
      end
    end
    // ---- R11 disabled channel ignored
    prog(3, 16'h0300, 16'h0002, 1'b0, 1'b0);
    dreq[3] = 1'b1;
    seen = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (hrq || dack != 0) seen = 1'b1;
    end
    dreq[3] = 1'b0;
    chk(!seen, "R11 no hrq", seen, 0);
    rd(3, 2'd0, d); chk(d == 16'h0300, "R11 addr untouched", d, 16'h0300);
    rd(3, 2'd1, d); chk(d == 16'h0002, "R11 count untouched", d, 2);
    // ---- R9 simultaneous requests on channels 1..3
    prog(1, 16'h2100, 16'h0001, 1'b0, 1'b1);
    prog(2, 16'h2200, 16'h0001, 1'b1, 1'b1);
    prog(3, 16'h2300, 16'h0001, 1'b0, 1'b1);
    b = n_ord;
    dreq[3:1] = 3'b111;
    wait_words(3, 2);
    idle(4);
    dreq = '0;
    chk(n_ord - b == 3, "R9 run count", n_ord - b, 3);
    chk(ord[b] == 1 && ord[b + 1] == 2 && ord[b + 2] == 3, "R9 order",
        ord[b] * 100 + ord[b + 1] * 10 + ord[b + 2], 123);
    rd(0, 2'd3, d); chk(d == 16'h000E, "R8 multi status", d, 16'hE);
    // ---- R9 no preemption mid-burst
    prog(2, 16'h3200, 16'h0003, 1'b0, 1'b1);
    prog(0, 16'h3000, 16'h0000, 1'b1, 1'b1);
    b = n_ord;
    dreq[2] = 1'b1;
    wait_words(2, 1);
    dreq[0] = 1'b1;
    wait_words(0, 1);
    idle(6);
    dreq = '0;
    chk(wc[2] - wc_base[2] == 4, "R9 burst kept", wc[2] - wc_base[2], 4);
    chk(n_ord - b == 2 && ord[b] == 2 && ord[b + 1] == 0, "R9 late high priority",
        ord[b] * 10 + ord[b + 1], 20);
    rd(0, 2'd3, d); chk(d == 16'h0005, "R8 status after preempt test", d, 5);
    // ---- R10 grant withdrawn mid-word
    auto_hlda = 1'b0; hlda_man = 1'b0;
    prog(0, 16'h0200, 16'h0005, 1'b0, 1'b1);
    dreq[0] = 1'b1;
    @(negedge clk);
    hlda_man = 1'b1;
    @(negedge clk);
    @(negedge clk);
    hlda_man = 1'b0;
    @(negedge clk);
    chk(memr && iow, "R10 hold completes", {memr, iow}, 2'b11);
    @(negedge clk);
    chk(bus_oe && !memr && !iow, "R10 release completes", bus_oe, 1);
    @(negedge clk);
    chk(!bus_oe && dack == 0 && addr_out == 0 && !(memr | memw | ior | iow),
        "R10 bus released", {bus_oe, dack}, 0);
    dreq[0] = 1'b0;
    idle(3);
    chk(!hrq, "R10 hrq dropped", hrq, 0);
    rd(0, 2'd0, d); chk(d == 16'h0201, "R10 one word addr", d, 16'h0201);
    rd(0, 2'd1, d); chk(d == 16'h0004, "R10 one word count", d, 4);
    auto_hlda = 1'b1;
    dreq[0] = 1'b1;
    for (int i = 0; i < 400 && !irq; i++) @(negedge clk);
    dreq[0] = 1'b0;
    idle(2);
    chk(wc[0] - wc_base[0] == 6, "R10 resumed total", wc[0] - wc_base[0], 6);
    rd(0, 2'd3, d); chk(d == 16'h0001, "R8 status R10", d, 1);
    // ---- R12 request withdrawn mid-burst, then resumed
    prog(1, 16'h0500, 16'h0009, 1'b1, 1'b1);
    dreq[1] = 1'b1;
    wait_words(1, 3);
    dreq[1] = 1'b0;
    idle(10);
    chk(wc[1] - wc_base[1] == 3 && !hrq, "R12 stop after word", wc[1] - wc_base[1], 3);
    rd(1, 2'd0, d); chk(d == 16'h0503, "R12 paused addr", d, 16'h0503);
    rd(1, 2'd1, d); chk(d == 16'h0006, "R12 paused count", d, 6);
    dreq[1] = 1'b1;
    for (int i = 0; i < 400 && !irq; i++) @(negedge clk);
    dreq[1] = 1'b0;
    idle(2);
    chk(wc[1] - wc_base[1] == 10, "R12 total words", wc[1] - wc_base[1], 10);
    rd(1, 2'd0, d); chk(d == 16'h050A, "R12 final addr", d, 16'h050A);
    rd(0, 2'd3, d); chk(d == 16'h0002, "R8 status R12", d, 2);
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    if (wd) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual expired expected finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end

endmodule